// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with a small word-wide register bus. A down-counter is loaded from a reload value picked by a 4-bit period code. Each code step doubles the period. Software keeps the system alive by writing a fixed key word to a restart register. If the counter reaches zero first, the block responds in one of two ways. It can start a system-reset pulse right away. Or it can raise an interrupt first, and only pulse reset if that interrupt is still pending at the next zero.

Software controls the block through a control word and a period register. The control word holds the enable, the response mode and the pulse-length field. Software can also read the live count and the interrupt status. A read of the acknowledge register clears the interrupt. The reset pulse lasts 2^(field+1) clock cycles. When the pulse ends, the counter reloads and starts counting again.

Top module: `wdog_top`

## Requirements
- R1: After reset, irqOut and sysRstOut are low, and the control word (0x00), period code (0x04) and status (0x10) read as 0. The count (0x08) reads the code-0 reload value.
- R2: Period code i gives a reload value of 2^(BASE_W+i)-1, with BASE_W=16 by default. When BASE_W+i is at least CNT_W, the reload value is all ones.
- R3: While control bit 0 (enable) is 0, the counter holds at the reload value, and irqOut and sysRstOut stay low.
- R4: The first clock edge after enable is set leaves the count at the reload value. Each later edge lowers the count by one. Register 0x08 returns the live count, zero-extended.
- R5: Writing the word 0x76 to 0x0C while counting reloads the counter. Any other value written there leaves the count running down as before.
- R6: With control bit 1 (mode) = 0, sysRstOut rises on the first edge that finds the count at zero. Counting from the reload value R, this is R+1 edges after the reload.
- R7: With mode = 1 and no interrupt pending, a zero count sets irqOut and status bit 0 and reloads the counter. sysRstOut is not asserted.
- R8: With mode = 1, a zero count that finds the interrupt still pending asserts sysRstOut.
- R9: A read of 0x14 returns the status in bit 0 and clears irqOut and the status bit. A later zero then raises a fresh interrupt instead of a reset.
- R10: sysRstOut stays high for 2^(f+1) cycles, where f is control bits [4:2]. The edge that ends the pulse clears the interrupt and reloads the counter.
- R11: Control bits [4:0] and period bits [3:0] read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irqOut | output | 1 | Pending timeout interrupt |
| sysRstOut | output | 1 | System-reset pulse |

## Verification
The assertions assume a single bus master that makes at most one access per cycle. They also assume no write to the period code arrives in the same cycle as a key write, so the reload value they compare against is the one the design used. The tests issue every access as one isolated cycle through a task. They change the period code only while the watchdog is disabled. They also never issue an acknowledge read on the exact edge where a zero count is reached.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_RANGE   = 8'h04;
  localparam logic [7:0] OFF_COUNT   = 8'h08;
  localparam logic [7:0] OFF_RESTART = 8'h0C;
  localparam logic [7:0] OFF_STATUS  = 8'h10;
  localparam logic [7:0] OFF_ACK     = 8'h14;
  localparam logic [31:0] KICK_KEY   = 32'h0000_0076;

  typedef struct packed {
    logic load;
    logic dec;
  } dpStrobe_t;

  typedef enum logic {
    ST_COUNT = 1'b0,
    ST_PULSE = 1'b1
  } wdState_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int BASE_W  = 16,
  parameter int RANGE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [RANGE_W-1:0] rangeCode,
  output logic [CNT_W-1:0]   cntVal,
  output logic [CNT_W-1:0]   reloadVal,
  output logic               cntZero
);
  localparam int NCODE = 1 << RANGE_W;
  localparam logic [CNT_W-1:0] RST_VAL =
    (BASE_W >= CNT_W) ? {CNT_W{1'b1}} : CNT_W'((64'd1 << BASE_W) - 64'd1);

  logic [CNT_W-1:0] reloadTab [NCODE];

  for (genvar i = 0; i < NCODE; i++) begin : g_tab
    if (BASE_W + i >= CNT_W) begin : g_sat
      assign reloadTab[i] = {CNT_W{1'b1}};
    end else begin : g_pow
      assign reloadTab[i] = CNT_W'((64'd1 << (BASE_W + i)) - 64'd1);
    end
  end

  assign reloadVal = reloadTab[rangeCode];
  assign cntZero   = (cntVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= RST_VAL;
    end else if (strobe.load) begin
      cntVal <= reloadVal;
    end else if (strobe.dec) begin
      cntVal <= cntVal - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int RANGE_W = 4,
  parameter int PULSE_W = 3,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic               cntZero,
  output logic [31:0]        busRdata,
  output logic               irqOut,
  output logic               sysRstOut,
  output dpStrobe_t          strobe,
  output logic               enBit,
  output logic               modeBit,
  output logic [PULSE_W-1:0] pulseSel,
  output logic [RANGE_W-1:0] rangeCode
);
  localparam int PCNT_W = (1 << PULSE_W) + 1;

  wdState_t          st;
  logic              irqPend;
  logic [PCNT_W-1:0] pulseCnt;
  logic              wrCtrl, wrRange, kick, rdAck;
  logic              timeout, goReset, pulseLast;
  logic [PCNT_W-1:0] pulseLen;

  assign wrCtrl  = busSel && busWr && (busAddr == ADDR_W'(OFF_CTRL));
  assign wrRange = busSel && busWr && (busAddr == ADDR_W'(OFF_RANGE));
  assign kick    = busSel && busWr && (busAddr == ADDR_W'(OFF_RESTART))
                   && (busWdata == KICK_KEY);
  assign rdAck   = busSel && !busWr && (busAddr == ADDR_W'(OFF_ACK));

  assign timeout   = enBit && (st == ST_COUNT) && !kick && cntZero;
  assign goReset   = !modeBit || irqPend;
  assign pulseLast = (st == ST_PULSE) && (pulseCnt == PCNT_W'(1));
  assign pulseLen  = PCNT_W'(1) << ({1'b0, pulseSel} + 1'b1);

  always_comb begin
    strobe.load = !enBit
                  || ((st == ST_COUNT) && kick)
                  || (timeout && !goReset)
                  || pulseLast;
    strobe.dec  = enBit && (st == ST_COUNT) && !kick && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      modeBit   <= 1'b0;
      pulseSel  <= '0;
      rangeCode <= '0;
      irqPend   <= 1'b0;
      st        <= ST_COUNT;
      pulseCnt  <= '0;
    end else begin
      if (wrCtrl) begin
        enBit    <= busWdata[0];
        modeBit  <= busWdata[1];
        pulseSel <= busWdata[2 +: PULSE_W];
      end
      if (wrRange) begin
        rangeCode <= busWdata[RANGE_W-1:0];
      end
      if (rdAck) begin
        irqPend <= 1'b0;
      end
      if (!enBit) begin
        irqPend  <= 1'b0;
        st       <= ST_COUNT;
        pulseCnt <= '0;
      end else begin
        case (st)
          ST_COUNT: begin
            if (timeout) begin
              if (goReset) begin
                st       <= ST_PULSE;
                pulseCnt <= pulseLen;
              end else begin
                irqPend <= 1'b1;
              end
            end
          end
          ST_PULSE: begin
            if (pulseLast) begin
              st      <= ST_COUNT;
              irqPend <= 1'b0;
            end else begin
              pulseCnt <= pulseCnt - 1'b1;
            end
          end
          default: st <= ST_COUNT;
        endcase
      end
    end
  end

  assign irqOut    = irqPend;
  assign sysRstOut = (st == ST_PULSE);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFF_CTRL):   busRdata = 32'({pulseSel, modeBit, enBit});
      ADDR_W'(OFF_RANGE):  busRdata = 32'(rangeCode);
      ADDR_W'(OFF_COUNT):  busRdata = 32'(cntVal);
      ADDR_W'(OFF_STATUS): busRdata = 32'(irqPend);
      ADDR_W'(OFF_ACK):    busRdata = 32'(irqPend);
      default:             busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int BASE_W  = 16,
  parameter int RANGE_W = 4,
  parameter int PULSE_W = 3,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output logic              sysRstOut
);
  dpStrobe_t          strobe;
  logic [CNT_W-1:0]   cntVal;
  logic [CNT_W-1:0]   reloadVal;
  logic               cntZero;
  logic               enBit;
  logic               modeBit;
  logic [PULSE_W-1:0] pulseSel;
  logic [RANGE_W-1:0] rangeCode;

  wdog_ctrl #(
    .CNT_W(CNT_W), .RANGE_W(RANGE_W), .PULSE_W(PULSE_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .cntVal(cntVal), .cntZero(cntZero),
    .busRdata(busRdata), .irqOut(irqOut), .sysRstOut(sysRstOut),
    .strobe(strobe), .enBit(enBit), .modeBit(modeBit),
    .pulseSel(pulseSel), .rangeCode(rangeCode)
  );

  wdog_dp #(
    .CNT_W(CNT_W), .BASE_W(BASE_W), .RANGE_W(RANGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rangeCode(rangeCode),
    .cntVal(cntVal), .reloadVal(reloadVal), .cntZero(cntZero)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 3,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busWdata,
  input logic               irqOut,
  input logic               sysRstOut,
  input logic               enBit,
  input logic               modeBit,
  input logic [PULSE_W-1:0] pulseSel,
  input logic [CNT_W-1:0]   cntVal,
  input logic [CNT_W-1:0]   reloadVal
);
  localparam int PCNT_W = (1 << PULSE_W) + 2;

  logic [PULSE_W-1:0] prevSel;
  logic               prevRst;
  logic [PCNT_W-1:0]  hiCnt;
  logic [PCNT_W-1:0]  expLen;
  logic               restartWr;

  assign restartWr = busSel && busWr && (busAddr == ADDR_W'(OFF_RESTART));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel <= '0;
      prevRst <= 1'b0;
      hiCnt   <= '0;
      expLen  <= '0;
    end else begin
      prevSel <= pulseSel;
      prevRst <= sysRstOut;
      hiCnt   <= sysRstOut ? hiCnt + 1'b1 : '0;
      if (sysRstOut && !prevRst) begin
        expLen <= PCNT_W'(1) << ({1'b0, prevSel} + 1'b1);
      end
    end
  end

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> (!sysRstOut && !irqOut));

  // R5
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restartWr && busWdata != KICK_KEY && enBit && !sysRstOut && cntVal != '0)
    |=> cntVal == $past(cntVal) - 1'b1);

  // R5
  good_key_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restartWr && busWdata == KICK_KEY && enBit && !sysRstOut)
    |=> cntVal == $past(reloadVal));

  // R7
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(modeBit));

  // R6
  reset_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> $past(cntVal) == '0);

  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sysRstOut) && $past(enBit)) |-> hiCnt == expLen);
endmodule

bind wdog_top wdog_chk #(
  .CNT_W(CNT_W), .PULSE_W(PULSE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .irqOut(irqOut),
  .sysRstOut(sysRstOut), .enBit(enBit), .modeBit(modeBit),
  .pulseSel(pulseSel), .cntVal(cntVal), .reloadVal(reloadVal)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;
  localparam int CNT_W  = 8;
  localparam int BASE_W = 4;
  localparam int ADDR_W = 8;
  localparam int R0     = 15;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              irqOut;
  logic              sysRstOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_top #(.CNT_W(CNT_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) i_wdog_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .sysRstOut(sysRstOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [31:0] data);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic peek(input logic [7:0] addr, output logic [31:0] data);
    busSel = 1'b0; busWr = 1'b0; busAddr = addr;
    #1 data = busRdata;
  endtask

  task automatic ackRead(output logic [31:0] data);
    busSel = 1'b1; busWr = 1'b0; busAddr = 8'h14;
    #1 data = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk("R1 irq", 32'(irqOut), 0);
    chk("R1 rst", 32'(sysRstOut), 0);
    peek(8'h00, v); chk("R1 ctrl", v, 0);
    peek(8'h04, v); chk("R1 range", v, 0);
    peek(8'h10, v); chk("R1 status", v, 0);
    peek(8'h08, v); chk("R1 count", v, R0);
  endtask

  task automatic testRanges();
    logic [31:0] v;
    busWrite(8'h04, 32'd2); waitCyc(1);
    peek(8'h08, v); chk("R2 code2", v, 63);
    busWrite(8'h04, 32'd5); waitCyc(1);
    peek(8'h08, v); chk("R2 saturate", v, 32'hFF);
    peek(8'h04, v); chk("R11 range readback", v, 5);
    busWrite(8'h00, 32'h1C);
    peek(8'h00, v); chk("R11 ctrl readback", v, 32'h1C);
    busWrite(8'h00, 32'h0);
    busWrite(8'h04, 32'd0); waitCyc(1);
  endtask

  task automatic testDisabled();
    logic [31:0] v;
    waitCyc(40);
    peek(8'h08, v); chk("R3 count held", v, R0);
    chk("R3 irq", 32'(irqOut), 0);
    chk("R3 rst", 32'(sysRstOut), 0);
  endtask

  task automatic testCountAndKey();
    logic [31:0] v;
    busWrite(8'h00, 32'h01);
    peek(8'h08, v); chk("R4 first edge", v, R0);
    waitCyc(5);
    peek(8'h08, v); chk("R4 live count", v, R0 - 5);
    busWrite(8'h0C, 32'h77);
    peek(8'h08, v); chk("R5 bad key ignored", v, R0 - 6);
    busWrite(8'h0C, 32'h76);
    peek(8'h08, v); chk("R5 key reload", v, R0);
    busWrite(8'h00, 32'h0);
  endtask

  task automatic testMode0();
    logic [31:0] v;
    busWrite(8'h00, 32'h05);
    waitCyc(R0);
    peek(8'h08, v); chk("R6 zero reached", v, 0);
    chk("R6 no early reset", 32'(sysRstOut), 0);
    waitCyc(1);
    chk("R6 reset asserted", 32'(sysRstOut), 1);
    chk("R6 no irq", 32'(irqOut), 0);
    for (int k = 1; k < 4; k++) begin
      waitCyc(1);
      chk("R10 pulse held", 32'(sysRstOut), 1);
    end
    waitCyc(1);
    chk("R10 pulse ended", 32'(sysRstOut), 0);
    peek(8'h08, v); chk("R10 reload after pulse", v, R0);
    busWrite(8'h00, 32'h0);
  endtask

  task automatic testMode1();
    logic [31:0] v;
    busWrite(8'h00, 32'h03);
    waitCyc(R0 + 1);
    chk("R7 irq raised", 32'(irqOut), 1);
    chk("R7 no reset", 32'(sysRstOut), 0);
    peek(8'h08, v); chk("R7 reloaded", v, R0);
    peek(8'h10, v); chk("R7 status", v, 1);
    ackRead(v); chk("R9 ack returns status", v, 1);
    chk("R9 irq cleared", 32'(irqOut), 0);
    peek(8'h10, v); chk("R9 status cleared", v, 0);
    waitCyc(R0 - 1);
    chk("R9 still clear", 32'(irqOut), 0);
    waitCyc(1);
    chk("R9 fresh irq", 32'(irqOut), 1);
    chk("R9 no reset", 32'(sysRstOut), 0);
    waitCyc(R0);
    chk("R8 not yet", 32'(sysRstOut), 0);
    waitCyc(1);
    chk("R8 reset on pending", 32'(sysRstOut), 1);
    waitCyc(1);
    chk("R10 two-cycle pulse", 32'(sysRstOut), 1);
    waitCyc(1);
    chk("R10 pulse ended", 32'(sysRstOut), 0);
    chk("R10 irq cleared", 32'(irqOut), 0);
    busWrite(8'h00, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    testReset();
    testRanges();
    testDisabled();
    testCountAndKey();
    testMode0();
    testMode1();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule